// File: doc/BRIEF.md
# Atomic Network Message Launch Unit

The processor composes an outgoing network message by writing words into a small descriptor array with ordinary stores. Word 0 is a header that holds an opcode and a destination node. Words after the header are either explicit payload words or DMA gather pairs. Each pair is an address word followed by a length word. A launch command gives the total descriptor length and the number of leading explicit words, header included. Every word past the explicit part is read as address/length pairs.

The launch is taken in one cycle and commits at the next clock edge, which stands for the writeback stage. A kill asserted in that commit cycle cancels the launch without trace. Nothing reaches the network port before commit. Once commit happens, two queuing cycles pass and then the whole packet streams out without gaps of its own making: the explicit words first, then the words fetched for each gather pair in order. Because no partial message can be left behind on the port, an interrupt handler can use the unit between two launches of interrupted code. Launching a header whose opcode lies in the privileged range while in user mode raises an exception pulse, and nothing is sent.

Top module: `mlu_launch_unit`

## Requirements
- R1: A store with `st_valid` high while `busy` is low writes `st_data` to descriptor word `st_idx`. The packet emits the stored values unchanged.
- R2: A committed packet carries the explicit words 0 to E-1 in index order, then the gathered words of each pair in pair order. The pairs are (L-E)/2 rounded down, and pair p sits at words E+2p (address) and E+2p+1 (length).
- R3: While a launch waits for commit, `busy` is high and `net_valid` is low. `net_valid` is never high while `busy` is low.
- R4: The opcode is header bits [31:24]. An opcode below 0x40 launched while `user_mode` is high in the commit cycle gives a one-cycle `priv_exc` in the cycle after the commit edge and sends nothing. In supervisor mode the same opcode is sent.
- R5: A launch sampled at clock edge A commits at edge A+1, and header word 0 is on the network port in the cycle that follows edge A+3.
- R6: `launch_kill` high in the cycle after the launch cancels it. No word is sent, no exception is raised, and `busy` is low after the commit edge.
- R7: `busy` stays high from launch acceptance until the last word. Launches and stores made while `busy` is high are ignored, so the descriptor is not changed while a packet drains.
- R8: Each pair with a nonzero length (bits [7:0] of its length word; higher bits ignored) issues a one-cycle `dma_req_valid` carrying the address and length. The unit forwards that many `dma_rsp_valid` words to the network. A zero-length pair issues no request and no words.
- R9: After reset, `busy`, `net_valid`, `priv_exc` and `dma_req_valid` are low.
- R10: A length of 0 counts as 1 and a length above 16 counts as 16. An explicit count of 0 counts as 1 and one above the length counts as the length. A single word left over after the pairs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Descriptor store strobe |
| st_idx | input | 4 | Descriptor word index |
| st_data | input | 32 | Descriptor store data |
| launch_valid | input | 1 | Launch command strobe |
| launch_len | input | 5 | Descriptor length in words |
| launch_exp | input | 5 | Explicit word count, header included |
| launch_kill | input | 1 | Cancels the launch in its commit cycle |
| user_mode | input | 1 | High when the launch comes from user mode |
| busy | output | 1 | Launch pending or packet draining |
| priv_exc | output | 1 | Privilege violation pulse |
| net_valid | output | 1 | Network word valid |
| net_data | output | 32 | Network word |
| dma_req_valid | output | 1 | Gather request strobe |
| dma_addr | output | 32 | Gather start address |
| dma_len | output | 8 | Gather word count |
| dma_rsp_valid | input | 1 | Gathered word valid |
| dma_rsp_data | input | 32 | Gathered word |

## Verification
The assertions check on every cycle that the port stays silent outside a busy period and for the two cycles after a commit, and that the first word arrives on the third cycle. They also check that a killed or faulting launch leaves no exception or activity behind, that commits only start in an idle sequencer, that gather requests are single pulses, and that the header stays frozen while busy. Only the bench scenarios can show that the emitted words equal what was stored, in the right order and with the right gathered counts. The same holds for the normalization of out-of-range length fields, and for the fact that stores and launches issued during a drain leave no trace in later packets.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_QUEUE, S_EXPL, S_DREQ, S_DDATA
  } seq_state_e;

  // total descriptor length after clamping into 1..depth
  function automatic int norm_len(int len, int depth);
    if (len < 1) return 1;
    if (len > depth) return depth;
    return len;
  endfunction

  // explicit word count after clamping into 1..len_n
  function automatic int norm_exp(int expl, int len_n);
    if (expl < 1) return 1;
    if (expl > len_n) return len_n;
    return expl;
  endfunction

  // whole address/length pairs after the explicit words
  function automatic int pair_count(int len_n, int exp_n);
    return (len_n - exp_n) / 2;
  endfunction

  function automatic logic op_is_priv(int op, int limit);
    return op < limit;
  endfunction

endpackage

// File: rtl/mlu_desc_array.sv
module mlu_desc_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int OPW   = 8,
  parameter int LENW  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [LENW-1:0]  rb_len,
  output logic [OPW-1:0]   hdr_op
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_comb begin
    ra_data = mem[ra_idx];
    rb_len  = mem[rb_idx][LENW-1:0];
    hdr_op  = mem[0][DW-1 -: OPW];
  end

endmodule

// File: rtl/mlu_launch_ctl.sv
module mlu_launch_ctl
  import mlu_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OPW        = 8,
  parameter int PRIV_LIMIT = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch_valid,
  input  logic [CW-1:0]  launch_len,
  input  logic [CW-1:0]  launch_exp,
  input  logic           launch_kill,
  input  logic           user_mode,
  input  logic [OPW-1:0] hdr_op,
  input  logic           seq_busy,
  output logic           pend,
  output logic           commit,
  output logic           priv_exc,
  output logic [CW-1:0]  exp_n,
  output logic [CW-1:0]  pair_n
);

  logic [CW-1:0] len_q, exp_raw_q, len_norm;
  logic          violate;
  logic          fault_evt;

  always_comb begin
    violate   = user_mode && op_is_priv(int'(hdr_op), PRIV_LIMIT);
    commit    = pend && !launch_kill && !violate;
    fault_evt = pend && !launch_kill && violate;
    len_norm  = CW'(norm_len(int'(len_q), DEPTH));
    exp_n     = CW'(norm_exp(int'(exp_raw_q), int'(len_norm)));
    pair_n    = CW'(pair_count(int'(len_norm), int'(exp_n)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      priv_exc  <= 1'b0;
      len_q     <= '0;
      exp_raw_q <= '0;
    end else begin
      priv_exc <= fault_evt;
      if (pend) begin
        pend <= 1'b0;
      end else if (launch_valid && !seq_busy) begin
        pend      <= 1'b1;
        len_q     <= launch_len;
        exp_raw_q <= launch_exp;
      end
    end
  end

  // R6: a killed launch leaves no exception behind
  assert_kill_no_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && launch_kill) |=> !priv_exc);

  // R4: a faulting launch never starts the sequencer
  assert_exc_no_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
    priv_exc |-> !seq_busy);

endmodule

// File: rtl/mlu_stream_seq.sv
module mlu_stream_seq
  import mlu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int LENW  = 8,
  parameter int QWAIT = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = IDX_W + 1,
  localparam int QCW   = (QWAIT > 1) ? $clog2(QWAIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CW-1:0]    exp_n,
  input  logic [CW-1:0]    pair_n,
  input  logic [DW-1:0]    ra_data,
  input  logic [LENW-1:0]  rb_len,
  input  logic             dma_rsp_valid,
  input  logic [DW-1:0]    dma_rsp_data,
  output logic             active,
  output logic [IDX_W-1:0] ra_idx,
  output logic [IDX_W-1:0] rb_idx,
  output logic             net_valid,
  output logic [DW-1:0]    net_data,
  output logic             dma_req_valid,
  output logic [DW-1:0]    dma_addr,
  output logic [LENW-1:0]  dma_len
);

  seq_state_e       state;
  logic [QCW-1:0]   qcnt;
  logic [IDX_W-1:0] widx, pidx;
  logic [CW-1:0]    exp_q, pairs_q, left;
  logic [LENW-1:0]  rem;
  logic             last_expl, last_pair, queue_done;

  always_comb begin
    active        = (state != S_IDLE);
    ra_idx        = (state == S_EXPL) ? widx : pidx;
    rb_idx        = pidx + IDX_W'(1);
    last_expl     = ({1'b0, widx} == exp_q - CW'(1));
    last_pair     = (left == CW'(1));
    queue_done    = (qcnt == QCW'(QWAIT - 1));
    net_valid     = (state == S_EXPL) || (state == S_DDATA && dma_rsp_valid);
    net_data      = (state == S_EXPL) ? ra_data : dma_rsp_data;
    dma_req_valid = (state == S_DREQ) && (rb_len != '0);
    dma_addr      = ra_data;
    dma_len       = rb_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      qcnt    <= '0;
      widx    <= '0;
      pidx    <= '0;
      exp_q   <= '0;
      pairs_q <= '0;
      left    <= '0;
      rem     <= '0;
    end else begin
      case (state)
        S_IDLE: if (commit) begin
          state   <= S_QUEUE;
          qcnt    <= '0;
          exp_q   <= exp_n;
          pairs_q <= pair_n;
        end
        S_QUEUE: if (queue_done) begin
          state <= S_EXPL;
          widx  <= '0;
        end else begin
          qcnt <= qcnt + QCW'(1);
        end
        S_EXPL: if (last_expl) begin
          if (pairs_q != '0) begin
            state <= S_DREQ;
            pidx  <= exp_q[IDX_W-1:0];
            left  <= pairs_q;
          end else begin
            state <= S_IDLE;
          end
        end else begin
          widx <= widx + IDX_W'(1);
        end
        S_DREQ: if (rb_len != '0) begin
          state <= S_DDATA;
          rem   <= rb_len;
        end else if (last_pair) begin
          state <= S_IDLE;
        end else begin
          pidx <= pidx + IDX_W'(2);
          left <= left - CW'(1);
        end
        S_DDATA: if (dma_rsp_valid) begin
          if (rem != LENW'(1)) begin
            rem <= rem - LENW'(1);
          end else if (last_pair) begin
            state <= S_IDLE;
          end else begin
            state <= S_DREQ;
            pidx  <= pidx + IDX_W'(2);
            left  <= left - CW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a commit only ever meets an idle sequencer
  assert_commit_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (state == S_IDLE));

  // R8: each gather request is a single-cycle pulse
  assert_dma_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid |=> !dma_req_valid);

  generate
    if (QWAIT == 2) begin : g_gap_chk
      // R5: two silent queuing cycles, then the header word
      assert_queue_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !net_valid ##1 !net_valid ##1 net_valid);
    end
  endgenerate

endmodule

// File: rtl/mlu_launch_unit.sv
module mlu_launch_unit
  import mlu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int DEPTH      = 16,
  parameter int OPW        = 8,
  parameter int LENW       = 8,
  parameter int PRIV_LIMIT = 64,
  parameter int QWAIT      = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [DW-1:0]    st_data,
  input  logic             launch_valid,
  input  logic [CW-1:0]    launch_len,
  input  logic [CW-1:0]    launch_exp,
  input  logic             launch_kill,
  input  logic             user_mode,
  output logic             busy,
  output logic             priv_exc,
  output logic             net_valid,
  output logic [DW-1:0]    net_data,
  output logic             dma_req_valid,
  output logic [DW-1:0]    dma_addr,
  output logic [LENW-1:0]  dma_len,
  input  logic             dma_rsp_valid,
  input  logic [DW-1:0]    dma_rsp_data
);

  logic             pend, commit, seq_active, arr_we;
  logic [CW-1:0]    exp_n, pair_n;
  logic [IDX_W-1:0] ra_idx, rb_idx;
  logic [DW-1:0]    ra_data;
  logic [LENW-1:0]  rb_len;
  logic [OPW-1:0]   hdr_op;

  assign busy   = pend || seq_active;
  assign arr_we = st_valid && !busy;

  mlu_desc_array #(.DW(DW), .DEPTH(DEPTH), .OPW(OPW), .LENW(LENW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .widx(st_idx), .wdata(st_data),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_len(rb_len),
    .hdr_op(hdr_op)
  );

  mlu_launch_ctl #(.DEPTH(DEPTH), .OPW(OPW), .PRIV_LIMIT(PRIV_LIMIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
    .launch_len(launch_len), .launch_exp(launch_exp),
    .launch_kill(launch_kill), .user_mode(user_mode), .hdr_op(hdr_op),
    .seq_busy(seq_active), .pend(pend), .commit(commit),
    .priv_exc(priv_exc), .exp_n(exp_n), .pair_n(pair_n)
  );

  mlu_stream_seq #(.DW(DW), .DEPTH(DEPTH), .LENW(LENW), .QWAIT(QWAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .exp_n(exp_n), .pair_n(pair_n),
    .ra_data(ra_data), .rb_len(rb_len), .dma_rsp_valid(dma_rsp_valid),
    .dma_rsp_data(dma_rsp_data), .active(seq_active), .ra_idx(ra_idx),
    .rb_idx(rb_idx), .net_valid(net_valid), .net_data(net_data),
    .dma_req_valid(dma_req_valid), .dma_addr(dma_addr), .dma_len(dma_len)
  );

  // R3: the port is silent whenever no launch is in flight
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !net_valid);

  // R7: the header cannot change while a launch is in flight
  assert_hdr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hdr_op));

endmodule

// File: tb/tb_mlu_launch_unit.sv
module tb_mlu_launch_unit;
  localparam int DW = 32, DEPTH = 16, IDX_W = 4, CW = 5, LENW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, st_valid, launch_valid, launch_kill, user_mode;
  logic [IDX_W-1:0] st_idx;
  logic [DW-1:0] st_data, net_data, dma_addr, dma_rsp_data;
  logic [CW-1:0] launch_len, launch_exp;
  logic busy, priv_exc, net_valid, dma_req_valid, dma_rsp_valid;
  logic [LENW-1:0] dma_len;

  mlu_launch_unit dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_idx(st_idx),
    .st_data(st_data), .launch_valid(launch_valid), .launch_len(launch_len),
    .launch_exp(launch_exp), .launch_kill(launch_kill), .user_mode(user_mode),
    .busy(busy), .priv_exc(priv_exc), .net_valid(net_valid),
    .net_data(net_data), .dma_req_valid(dma_req_valid), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_rsp_valid(dma_rsp_valid),
    .dma_rsp_data(dma_rsp_data)
  );

  typedef struct packed {
    logic [4:0] len; logic [4:0] expl; logic user;
    logic [7:0] op;  logic [7:0] d0;   logic [7:0] d1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd3,  1'b1, 8'h80, 8'd0, 8'd0},
    '{5'd5,  5'd1,  1'b0, 8'h10, 8'd3, 8'd2},
    '{5'd4,  5'd2,  1'b1, 8'hC3, 8'd4, 8'd0},
    '{5'd6,  5'd6,  1'b0, 8'h41, 8'd0, 8'd0},
    '{5'd7,  5'd2,  1'b1, 8'h90, 8'd0, 8'd1},
    '{5'd0,  5'd0,  1'b1, 8'h7F, 8'd0, 8'd0},
    '{5'd16, 5'd16, 1'b0, 8'h55, 8'd0, 8'd0},
    '{5'd20, 5'd18, 1'b0, 8'hA4, 8'd0, 8'd0},
    '{5'd3,  5'd9,  1'b1, 8'hA0, 8'd0, 8'd0}
  };

  int errors = 0, checks = 0, cyc = 0;
  int got_n = 0, first_cyc = 0, launch_cyc = 0, dreqs = 0;
  int exp_cnt, dcnt = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] expw [512];
  logic [DW-1:0] gotw [512];
  logic [DW-1:0] dbase = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // network collector, 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n && net_valid) begin
      if (got_n < 512) gotw[got_n] = net_data;
      if (got_n == 0) first_cyc = cyc;
      got_n++;
    end
  end

  // gather model: answers a request with len words counting up from addr
  always @(negedge clk) begin
    if (!rst_n) begin
      dma_rsp_valid = 1'b0; dcnt = 0;
    end else if (dcnt != 0) begin
      dma_rsp_valid = 1'b1; dma_rsp_data = dbase;
      dbase = dbase + 1; dcnt--;
    end else begin
      dma_rsp_valid = 1'b0;
      if (dma_req_valid) begin
        dcnt = int'(dma_len); dbase = dma_addr; dreqs++;
      end
    end
  end

  task automatic store(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_idx = IDX_W'(idx); st_data = d;
    @(posedge clk); #1 st_valid = 1'b0;
  endtask

  task automatic launch(input int len, input int expl, input bit user);
    @(negedge clk);
    launch_valid = 1'b1; launch_len = CW'(len); launch_exp = CW'(expl);
    user_mode = user;
    @(negedge clk);
    launch_valid = 1'b0; launch_cyc = cyc;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #3;
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_words(input string req);
    chk(got_n == exp_cnt, req, "word count", got_n, exp_cnt);
    for (int i = 0; i < exp_cnt && i < got_n; i++)
      chk(gotw[i] === expw[i], req, $sformatf("word %0d", i), gotw[i], expw[i]);
  endtask

  task automatic run_vec(input int v);
    int nl, ne, np, nz;
    logic [7:0] dl;
    vec_t t;
    t  = VECS[v];
    nl = (t.len == 0) ? 1 : ((int'(t.len) > DEPTH) ? DEPTH : int'(t.len));
    ne = (t.expl == 0) ? 1 : int'(t.expl);
    if (ne > nl) ne = nl;
    np = (nl - ne) >> 1;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == 0) shadow[k] = {t.op, 16'h0, 8'(v + 3)};
      else if (k < ne) shadow[k] = 32'hC000_0000 | (v << 8) | k;
      else if (((k - ne) & 1) == 0) shadow[k] = 32'h4000_0000 + v * 4096 + k * 32;
      else shadow[k] = {24'hBEEF00, ((k - ne) >> 1) == 0 ? t.d0 : t.d1};
      store(k, shadow[k]);
    end
    exp_cnt = 0; nz = 0;
    for (int k = 0; k < ne; k++) expw[exp_cnt++] = shadow[k];
    for (int p = 0; p < np; p++) begin
      dl = shadow[ne + 2 * p + 1][7:0];
      if (dl != 0) nz++;
      for (int i = 0; i < int'(dl); i++) expw[exp_cnt++] = shadow[ne + 2 * p] + i;
    end
    got_n = 0; dreqs = 0;
    launch(int'(t.len), int'(t.expl), t.user);
    chk(busy && !net_valid, "R3", "pending cycle busy/quiet", {busy, net_valid}, 2'b10);
    wait_idle();
    compare_words((v >= 5) ? "R10" : ((np > 0) ? "R8" : "R1"));
    chk(got_n == exp_cnt, "R2", $sformatf("vector %0d length", v), got_n, exp_cnt);
    chk(dreqs == nz, "R8", "gather requests", dreqs, nz);
    chk(first_cyc - launch_cyc == 3, "R5", "first word latency",
        first_cyc - launch_cyc, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; launch_valid = 1'b0; launch_kill = 1'b0;
    user_mode = 1'b0; st_idx = '0; st_data = '0; launch_len = '0; launch_exp = '0;
    repeat (3) @(negedge clk);
    chk({busy, net_valid, priv_exc, dma_req_valid} == 4'b0, "R9", "reset outputs",
        {busy, net_valid, priv_exc, dma_req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R4: privileged opcode in user mode
    store(0, {8'h20, 24'h000005});
    got_n = 0;
    launch(1, 1, 1'b1);
    @(negedge clk); #3;
    chk(priv_exc === 1'b1, "R4", "exception pulse", priv_exc, 1);
    chk(busy === 1'b0, "R4", "busy after fault", busy, 0);
    @(negedge clk); #3;
    chk(priv_exc === 1'b0, "R4", "pulse width", priv_exc, 0);
    repeat (6) @(negedge clk);
    chk(got_n == 0, "R4", "words after fault", got_n, 0);

    // R6: killed launches, supervisor and faulting user
    store(0, {8'h90, 24'h000007});
    got_n = 0;
    launch(2, 2, 1'b0);
    launch_kill = 1'b1;
    @(negedge clk); launch_kill = 1'b0; #3;
    chk(busy === 1'b0, "R6", "busy after kill", busy, 0);
    store(0, {8'h20, 24'h000007});
    launch(1, 1, 1'b1);
    launch_kill = 1'b1;
    @(negedge clk); launch_kill = 1'b0; #3;
    chk(priv_exc === 1'b0, "R6", "no exception on kill", priv_exc, 0);
    repeat (6) @(negedge clk);
    chk(got_n == 0, "R6", "words after kill", got_n, 0);

    // R7: stores and a launch during a drain are ignored
    for (int k = 0; k < 8; k++) begin
      shadow[k] = (k == 0) ? {8'h90, 24'h000009} : 32'h7700_0000 + k;
      store(k, shadow[k]);
    end
    exp_cnt = 8;
    for (int k = 0; k < 8; k++) expw[k] = shadow[k];
    got_n = 0;
    launch(8, 8, 1'b0);
    for (int i = 0; i < 20 && got_n < 2; i++) @(negedge clk);
    store(0, 32'hDEAD_0000);
    store(3, 32'hDEAD_0003);
    #3 chk(busy === 1'b1, "R7", "busy during drain", busy, 1);
    launch(4, 4, 1'b0);
    wait_idle();
    compare_words("R7");
    got_n = 0;
    repeat (8) @(negedge clk);
    chk(got_n == 0, "R7", "launch while busy ignored", got_n, 0);
    launch(8, 8, 1'b0);
    wait_idle();
    compare_words("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule